// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Synchronous SRAM

This block models a synchronous static memory with a dedicated read port and a dedicated write port that share one address bus. Every access moves a pair of 18-bit words, one per half clock period, so a single address stands for a 36-bit slot. The read port drives its own output bus and the write port takes data on its own input bus. A read and a write can therefore be started in the same clock period with no bus turnaround.

The input clock `clk` plays the role of the K/K# pair: its rising edge is K and its falling edge is K#. A read select sampled low on a rising edge starts a read from the address present at that edge. A write select sampled low on a rising edge starts a write. The first write word and its lane enables are taken on that rising edge; the write address, the second word and its lane enables are taken on the following falling edge. Read data leaves through output registers clocked by `c_clk` and its inverse. In single-clock mode those registers are clocked by `clk` instead. The storage array is built from registers and is sized by a parameter.

Top module: `qdr_burst2_sram`

## Requirements
- R1: With `wps_n` low at a rising edge, `d`/`bw_n` at that edge form word 0 (bits 17:0 of the slot), and `d`/`bw_n`/`addr` at the next falling edge form word 1 and the write address; both words are stored at that address.
- R2: With `rps_n` low and address A at rising edge n, `q` shows word 0 of slot A after the next rising edge of the output clock and word 1 after the falling edge that follows it; back-to-back reads stream without gaps.
- R3: A read and a write started at the same rising edge to different addresses both complete, and neither disturbs the other.
- R4: A read started at the same rising edge as a write to the same address returns the newly written words.
- R5: `bw_n[0]` guards bits 8:0 and `bw_n[1]` guards bits 17:9 of the word sampled with it; a lane whose enable is high keeps its stored contents.
- R6: With `rps_n` high at a rising edge no read starts, and `q` keeps its last value.
- R7: With `wps_n` high at a rising edge no write happens, whatever `addr`, `d` and `bw_n` carry.
- R8: With `single_mode` low the output registers follow `c_clk`, so a stopped `c_clk` freezes `q`; with `single_mode` high they follow `clk`.
- R9: A low `rst_n` seen on clock edges clears `q` to zero and cancels any burst in flight; the array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; rising edge is K, falling edge is K# |
| rst_n | input | 1 | Synchronous active-low reset |
| c_clk | input | 1 | Output clock; its falling edge serves as C# |
| single_mode | input | 1 | High: output registers run on `clk` instead of `c_clk` |
| addr | input | ADDR_W | Shared address: read address on K, write address on K# |
| rps_n | input | 1 | Active-low read port select, sampled on K |
| wps_n | input | 1 | Active-low write port select, sampled on K |
| d | input | 18 | Write data, one word on K and one on K# |
| bw_n | input | 2 | Active-low lane write enables, one per 9-bit lane, sampled with each word |
| q | output | 18 | Read data, word 0 then word 1 |

## Verification
A reference array in the bench is first filled through the write port. A vector table then drives lone writes, lone reads, concurrent read and write to different slots, and concurrent read and write to one slot. The same-slot case separates forwarding from a stale array read. Writes with mixed lane enables and with both lanes blocked show whether enables are applied per word and per lane. Idle cycles and writes with the select high show that `q` holds and the array stays untouched. Word 0 and word 1 always differ, so a swapped burst order is caught. Directed runs switch the output clock source, stop `c_clk`, and pulse reset while a burst is in flight.

// File: rtl/qdr_sram_pkg.sv
// Shared widths for the burst-of-two SRAM model.
// Assumes the data word is a whole number of byte lanes.
package qdr_sram_pkg;
    parameter int WORD_W = 18;
    parameter int LANE_W = 9;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int PAIR_W = 2 * WORD_W;
    localparam int PLANES = 2 * LANES;
endpackage

// File: rtl/qdr_wr_capture.sv
// Write-port capture: takes the select, word 0 and its lane enables on the
// rising edge. Presents the full pair, lane keep mask and address, which the
// array commits on the following falling edge.
// Assumes addr, d and bw_n are stable around the falling edge.
module qdr_wr_capture
    import qdr_sram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wps_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] d,
    input  logic [LANES-1:0]  bw_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PAIR_W-1:0] wr_data,
    output logic [PLANES-1:0] wr_keep
);
    logic [WORD_W-1:0] word0_q;
    logic [LANES-1:0]  keep0_q;

    // Capture the write request and word 0 on K.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            word0_q <= '0;
            keep0_q <= '1;
        end else begin
            wr_en   <= ~wps_n;
            word0_q <= d;
            keep0_q <= bw_n;
        end
    end

    // Word 1, its enables and the address come straight from the pins for K#.
    always_comb begin
        wr_addr = addr;
        wr_data = {d, word0_q};
        wr_keep = {bw_n, keep0_q};
    end
endmodule

// File: rtl/qdr_array.sv
// Register-built storage of 2**ADDR_W slots of two words each.
// Writes commit on the falling edge, lane by lane. The read port is
// combinational and forwards lanes written in the same half-cycle.
// Assumes no reset of contents is wanted.
module qdr_array
    import qdr_sram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic [PLANES-1:0] wr_keep,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PAIR_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [PAIR_W-1:0] mem [DEPTH];
    logic              hit;

    // Self-timed commit on K#, only for enabled lanes.
    always_ff @(negedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < PLANES; l++) begin
                if (!wr_keep[l]) begin
                    mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Read with forwarding of a write landing on the same slot.
    always_comb begin
        hit     = wr_en && (wr_addr == rd_addr);
        rd_data = mem[rd_addr];
        for (int l = 0; l < PLANES; l++) begin
            if (hit && !wr_keep[l]) begin
                rd_data[l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/qdr_rd_path.sv
// Read request path: samples select and address on K and fetches the slot on
// the following K#, after any write of the same period has been merged.
// Assumes the array read port is combinational.
module qdr_rd_path
    import qdr_sram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rps_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAIR_W-1:0] fetch_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_pend,
    output logic [PAIR_W-1:0] rd_pair
);
    logic rd_go;

    // Latch the read request on K.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_go   <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_go   <= ~rps_n;
            rd_addr <= addr;
        end
    end

    // Fetch the slot on K#, ready for the output stage.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_pair <= '0;
        end else begin
            rd_pend <= rd_go;
            if (rd_go) begin
                rd_pair <= fetch_data;
            end
        end
    end
endmodule

// File: rtl/qdr_out_stage.sv
// Output registers on the output clock: word 0 on its rising edge, word 1
// on its falling edge. A toggle pair avoids two processes driving q.
// Assumes rd_pend/rd_pair change only on falling edges of the input clock.
module qdr_out_stage
    import qdr_sram_pkg::*;
(
    input  logic              oclk,
    input  logic              rst_n,
    input  logic              rd_pend,
    input  logic [PAIR_W-1:0] rd_pair,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] lo_q, hi_q;
    logic              hi_pend, tog_r, tog_f;

    // Rising output edge: load both words and show word 0.
    always_ff @(posedge oclk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            hi_pend <= 1'b0;
            tog_r   <= 1'b0;
        end else begin
            hi_pend <= rd_pend;
            if (rd_pend) begin
                lo_q  <= rd_pair[WORD_W-1:0];
                hi_q  <= rd_pair[PAIR_W-1:WORD_W];
                tog_r <= tog_f;
            end
        end
    end

    // Falling output edge: switch to word 1 of a live burst.
    always_ff @(negedge oclk) begin
        if (!rst_n) begin
            tog_f <= 1'b0;
        end else if (hi_pend) begin
            tog_f <= ~tog_r;
        end
    end

    assign q = (tog_r ^ tog_f) ? hi_q : lo_q;
endmodule

// File: rtl/qdr_burst2_sram.sv
// Top of the burst-of-two SRAM model: write capture, array, read path and
// output stage. The output clock is c_clk, or clk in single-clock mode.
// Assumes clk and c_clk share one domain with aligned edges.
module qdr_burst2_sram
    import qdr_sram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_clk,
    input  logic              single_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rps_n,
    input  logic              wps_n,
    input  logic [WORD_W-1:0] d,
    input  logic [LANES-1:0]  bw_n,
    output logic [WORD_W-1:0] q
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PAIR_W-1:0] wr_data, fetch_data, rd_pair;
    logic [PLANES-1:0] wr_keep;
    logic              rd_pend;
    logic              oclk;

    assign oclk = single_mode ? clk : c_clk;

    qdr_wr_capture #(.ADDR_W(ADDR_W)) i_wr (
        .clk(clk), .rst_n(rst_n), .wps_n(wps_n), .addr(addr), .d(d),
        .bw_n(bw_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_keep(wr_keep)
    );

    qdr_array #(.ADDR_W(ADDR_W)) i_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_keep(wr_keep), .rd_addr(rd_addr), .rd_data(fetch_data)
    );

    qdr_rd_path #(.ADDR_W(ADDR_W)) i_rd (
        .clk(clk), .rst_n(rst_n), .rps_n(rps_n), .addr(addr),
        .fetch_data(fetch_data), .rd_addr(rd_addr), .rd_pend(rd_pend),
        .rd_pair(rd_pair)
    );

    qdr_out_stage i_out (
        .oclk(oclk), .rst_n(rst_n), .rd_pend(rd_pend), .rd_pair(rd_pair),
        .q(q)
    );
endmodule

// File: rtl/qdr_sram_checker.sv
// Protocol checks for qdr_burst2_sram, attached by bind.
module qdr_sram_checker
    import qdr_sram_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              single_mode,
    input logic              rps_n,
    input logic              wps_n,
    input logic              wr_en,
    input logic              rd_pend,
    input logic [PAIR_W-1:0] rd_pair,
    input logic [WORD_W-1:0] q
);
    AST_WRITE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !wps_n |=> wr_en); // R1
    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wps_n |=> !wr_en); // R7
    AST_READ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !rps_n |=> rd_pend); // R2
    AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rps_n |=> !rd_pend); // R6
    AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && rd_pend) |=> (!single_mode || q == $past(rd_pair[PAIR_W-1:WORD_W]))); // R2
    AST_RESET_CLEARS: assert property (@(posedge clk)
        (!rst_n && single_mode) |=> (q == '0)); // R9
endmodule

bind qdr_burst2_sram qdr_sram_checker i_chk (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .rps_n(rps_n),
    .wps_n(wps_n), .wr_en(wr_en), .rd_pend(rd_pend), .rd_pair(rd_pair), .q(q)
);

// File: tb/test_qdr_burst2_sram.sv
module test_qdr_burst2_sram;
    localparam int AW = 4;

    typedef struct packed {
        logic        rps_n;
        logic        wps_n;
        logic [3:0]  raddr;
        logic [3:0]  waddr;
        logic [17:0] w0;
        logic [17:0] w1;
        logic [1:0]  bw0;
        logic [1:0]  bw1;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 4'd0, 4'd3, 18'h15555, 18'h0AAAA, 2'b00, 2'b00, 4'd1}, // R1 write slot 3
        '{1'b0, 1'b1, 4'd3, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd1}, // R1 read back slot 3
        '{1'b0, 1'b0, 4'd5, 4'd6, 18'h3F00F, 18'h00FF0, 2'b00, 2'b00, 4'd3}, // R3 read 5 while writing 6
        '{1'b0, 1'b1, 4'd6, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd3}, // R3 read 6
        '{1'b0, 1'b0, 4'd7, 4'd7, 18'h2468A, 18'h13579, 2'b00, 2'b00, 4'd4}, // R4 same slot
        '{1'b1, 1'b0, 4'd0, 4'd8, 18'h3FFFF, 18'h3FFFF, 2'b10, 2'b01, 4'd6}, // R5 partial lanes
        '{1'b0, 1'b1, 4'd8, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd5}, // R5 read slot 8
        '{1'b1, 1'b1, 4'd0, 4'd9, 18'h12345, 18'h2BCDE, 2'b00, 2'b00, 4'd6}, // R7 blocked write, R6 idle
        '{1'b0, 1'b1, 4'd9, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd7}, // R7 slot 9 unchanged
        '{1'b0, 1'b0, 4'd4, 4'd4, 18'h00001, 18'h00002, 2'b11, 2'b11, 4'd5}, // R5 all lanes kept
        '{1'b0, 1'b1, 4'd3, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd2}, // R2 back to back
        '{1'b0, 1'b1, 4'd8, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd2}, // R2 back to back
        '{1'b1, 1'b1, 4'd0, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd6}, // R6 hold
        '{1'b1, 1'b1, 4'd0, 4'd0, 18'h00000, 18'h00000, 2'b11, 2'b11, 4'd6}  // R6 hold
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          c_en = 1'b1;
    logic          single_mode = 1'b1;
    logic          c_clk;
    logic [AW-1:0] addr = '0;
    logic          rps_n = 1'b1;
    logic          wps_n = 1'b1;
    logic [17:0]   d = '0;
    logic [1:0]    bw_n = 2'b11;
    logic [17:0]   q;

    int          checks = 0;
    int          fails = 0;
    logic [35:0] ref_mem [16];
    logic        prev_rd = 1'b0;
    logic [35:0] prev_exp = '0;
    logic [3:0]  prev_req = '0;
    logic [17:0] last_q = '0;

    always #2 clk = ~clk;
    assign c_clk = clk & c_en;

    qdr_burst2_sram #(.ADDR_W(AW)) i_qdr_burst2_sram (
        .clk(clk), .rst_n(rst_n), .c_clk(c_clk), .single_mode(single_mode),
        .addr(addr), .rps_n(rps_n), .wps_n(wps_n), .d(d), .bw_n(bw_n), .q(q)
    );

    task automatic check(input int req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: q=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One K period; checks the burst of the read issued one period earlier.
    task automatic run_cycle(input vec_t v);
        logic live;
        addr = v.raddr; d = v.w0; bw_n = v.bw0; rps_n = v.rps_n; wps_n = v.wps_n;
        @(posedge clk); #1;
        live = single_mode | c_en;
        if (prev_rd && live) check(prev_req, q, prev_exp[17:0]);   // R2 word 0
        else check(6, q, last_q);                                  // R6 hold
        addr = v.waddr; d = v.w1; bw_n = v.bw1;
        @(negedge clk); #1;
        if (prev_rd && live) begin
            check(prev_req, q, prev_exp[35:18]);                   // R2 word 1
            last_q = prev_exp[35:18];
        end else check(6, q, last_q);
        if (!v.wps_n) begin
            for (int l = 0; l < 4; l++) begin
                if (!(({v.bw1, v.bw0} >> l) & 1'b1))
                    ref_mem[v.waddr][l*9 +: 9] = ({v.w1, v.w0} >> (l*9));
            end
        end
        prev_rd  = !v.rps_n;
        prev_exp = ref_mem[v.raddr];
        prev_req = v.req;
    endtask

    function automatic vec_t mk(input logic r, input logic w, input logic [3:0] ra,
                                input logic [3:0] wa, input logic [17:0] a0,
                                input logic [17:0] a1, input logic [3:0] rq);
        vec_t t;
        t = '{r, w, ra, wa, a0, a1, 2'b00, 2'b00, rq};
        return t;
    endfunction

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(9, q, 18'h0);                       // R9 reset state
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) begin         // R1 fill every slot
            run_cycle(mk(1'b1, 1'b0, 4'd0, 4'(a), {4'(a), 14'h0ABC}, {14'h1234, 4'(a)}, 4'd6));
        end
        for (int i = 0; i < NV; i++) run_cycle(TBL[i]);

        // R8: output on c_clk with single-clock mode off
        single_mode = 1'b0;
        run_cycle(mk(1'b0, 1'b1, 4'd3, 4'd0, 18'h0, 18'h0, 4'd8));
        run_cycle(mk(1'b1, 1'b1, 4'd0, 4'd0, 18'h0, 18'h0, 4'd8));
        run_cycle(mk(1'b1, 1'b1, 4'd0, 4'd0, 18'h0, 18'h0, 4'd8));
        // R8: stopped c_clk freezes q
        c_en = 1'b0;
        run_cycle(mk(1'b0, 1'b1, 4'd5, 4'd0, 18'h0, 18'h0, 4'd8));
        run_cycle(mk(1'b1, 1'b1, 4'd0, 4'd0, 18'h0, 18'h0, 4'd8));
        run_cycle(mk(1'b1, 1'b1, 4'd0, 4'd0, 18'h0, 18'h0, 4'd8));
        c_en = 1'b1;
        single_mode = 1'b1;
        run_cycle(mk(1'b1, 1'b1, 4'd0, 4'd0, 18'h0, 18'h0, 4'd8));

        // R9: reset while a burst is in flight
        run_cycle(mk(1'b0, 1'b1, 4'd7, 4'd0, 18'h0, 18'h0, 4'd9));
        rst_n = 1'b0;
        rps_n = 1'b1; wps_n = 1'b1;
        @(posedge clk); #1;
        check(9, q, 18'h0);                       // R9 burst cancelled
        @(negedge clk); #1;
        check(9, q, 18'h0);                       // R9 still clear
        rst_n = 1'b1;
        prev_rd = 1'b0;
        last_q = '0;
        run_cycle(mk(1'b0, 1'b1, 4'd7, 4'd0, 18'h0, 18'h0, 4'd9)); // R9 array kept
        run_cycle(mk(1'b1, 1'b1, 4'd0, 4'd0, 18'h0, 18'h0, 4'd6));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule